// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous DRAM out of power-up and then keeps its contents alive. After reset it waits out a settling pause, then runs a fixed number of dummy refresh cycles. Only then does it flag the memory as ready for normal traffic. From that point on, an interval timer schedules refreshes often enough to cover every row inside the retention period. Each refresh uses the mode in which the device's internal row counter supplies the row. In that mode the column strobe drops before the row strobe, and the address pins are not used.

The memory's strobe pins are shared with an access controller. Whenever the sequencer has work to do, it raises `req_o` and waits for `gni_i`. It drives the pins (`drive_o`) only while a cycle it started under grant is running. It releases the request once the last precharge interval of its work has elapsed. If the grant is held off, further timer expiries are counted, and those refreshes are issued back to back once the grant arrives. The write strobe is always high when the row strobe falls, so the device's test mode can never be entered.

A build parameter enables a low-power retention entry. While `sr_req_i` is high, the block runs one ordinary refresh and then holds both strobes low for at least the minimum retention-mode time. It then applies the longer exit precharge and runs one more ordinary refresh. All timing comes from nanosecond parameters converted to clock cycles through the clock-period parameter.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `req_o`, `init_done_o` and `drive_o` are low and `ras_n_o` and `cas_n_o` are high.
- R2: `req_o` stays low for the first PAUSE_CYC clock edges after reset release and is high after edge PAUSE_CYC, where PAUSE_CYC is PAUSE_NS divided by CLK_NS, rounded up.
- R3: `init_done_o` rises when exactly INIT_REFRESHES refresh cycles (default 8) have completed, and stays high from then until reset.
- R4: In every cycle of the row strobe, `cas_n_o` falls at least CSR_CYC clocks before `ras_n_o` falls, and it stays low for the whole time `ras_n_o` is low.
- R5: `we_n_o` is high at every falling edge of `ras_n_o`.
- R6: `ras_n_o` stays low for at least RAS_CYC clocks. After `ras_n_o` rises, the next fall of `cas_n_o` comes at least RP_CYC clocks later, where RP_CYC covers both the precharge and the RAS-high-to-CAS-fall minimum.
- R7: Once initialised, and with a prompt grant, the spacing between successive row-strobe falls never exceeds INTERVAL_CYC plus the length of one refresh and the grant latency.
- R8: `ras_n_o` and `cas_n_o` fall only while `drive_o` and `gnt_i` are high, and `drive_o` is never high while `req_o` is low.
- R9: Once raised, `req_o` stays high until the grant has come and the work is done. After the final precharge, `req_o` and `drive_o` fall with both strobes high.
- R10: Each interval expiry that occurs while the grant is withheld adds one pending refresh. On grant, all pending refreshes run back to back under one request.
- R11: When retention mode is enabled and `sr_req_i` is high, an ordinary refresh immediately precedes a row-strobe low period of at least RASS_CYC clocks. That period lasts as long as `sr_req_i` stays high. It is followed by at least RPS_CYC clocks of precharge and then, immediately, another ordinary refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sr_req_i | input | 1 | Request to hold the memory in low-power retention |
| gnt_i | input | 1 | Grant of the shared memory pins |
| req_o | output | 1 | Request for the shared memory pins |
| init_done_o | output | 1 | Power-up sequence complete |
| drive_o | output | 1 | Sequencer owns and drives the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write strobe, held high |

## Verification
The bench builds the block with a 20 ns clock period, a 2 µs power-up pause and a 2 µs refresh interval, so each is 100 cycles. The retention hold is shortened to 400 ns, which is 20 cycles. These values bring the power-up count, several refresh intervals, a burst of three postponed refreshes and a full retention entry and exit into a short run. The sub-100 ns strobe timings still come out at one to six cycles, so the edge ordering is measured at cycle resolution. Grant latency is drawn at random from zero to five cycles, which stresses the spacing bound and the request hold.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  // ceiling conversion, never below one cycle
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [1:0] {WV_IDLE, WV_SETUP, WV_ACTIVE, WV_PRECHG} wave_ph_e;

  typedef enum logic [2:0] {
    SQ_PAUSE, SQ_INIT, SQ_RUN, SQ_SR_PRE, SQ_SR_HOLD, SQ_SR_POST
  } seq_ph_e;

endpackage

// File: rtl/refresh_pacer.sv
module refresh_pacer #(
  parameter int unsigned INTERVAL_CYC = 1560,
  parameter int unsigned MAX_PEND     = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic done_i,
  output logic pend_o
);
  localparam int unsigned TW = $clog2(INTERVAL_CYC + 1);
  localparam int unsigned PW = $clog2(MAX_PEND + 1);

  logic [TW-1:0] tmr_q;
  logic [PW-1:0] pend_q;
  logic          expire, inc, dec;

  assign expire = run_i && (tmr_q == '0);
  assign inc    = expire && (pend_q != PW'(MAX_PEND));
  assign dec    = done_i && (pend_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= TW'(INTERVAL_CYC - 1);
      pend_q <= '0;
    end else if (!run_i) begin
      tmr_q  <= TW'(INTERVAL_CYC - 1);
      pend_q <= '0;
    end else begin
      // reload on every completed refresh as well as on expiry
      if (expire || done_i) tmr_q <= TW'(INTERVAL_CYC - 1);
      else                  tmr_q <= tmr_q - 1'b1;
      if (inc && !dec)      pend_q <= pend_q + 1'b1;
      else if (dec && !inc) pend_q <= pend_q - 1'b1;
    end
  end

  assign pend_o = (pend_q != '0);
endmodule

// File: rtl/cbr_wave.sv
module cbr_wave
  import dram_refresh_pkg::*;
#(
  parameter int unsigned CSR_CYC  = 1,
  parameter int unsigned RAS_CYC  = 6,
  parameter int unsigned RP_CYC   = 4,
  parameter int unsigned RASS_CYC = 10000,
  parameter int unsigned RPS_CYC  = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic self_i,
  input  logic hold_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int unsigned CMAX = umax(umax(CSR_CYC, RAS_CYC), umax(umax(RP_CYC, RASS_CYC), RPS_CYC));
  localparam int unsigned CW   = $clog2(CMAX + 1);

  wave_ph_e      ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          slf_q, slf_d;
  logic          ras_n_q, cas_n_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    slf_d = slf_q;
    unique case (ph_q)
      WV_IDLE: if (start_i) begin
        ph_d  = WV_SETUP;
        cnt_d = CW'(CSR_CYC - 1);
        slf_d = self_i;
      end
      WV_SETUP: if (cnt_q == '0) begin
        ph_d  = WV_ACTIVE;
        cnt_d = slf_q ? CW'(RASS_CYC - 1) : CW'(RAS_CYC - 1);
      end else cnt_d = cnt_q - 1'b1;
      WV_ACTIVE: if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      else if (!(slf_q && hold_i)) begin
        ph_d  = WV_PRECHG;
        cnt_d = slf_q ? CW'(RPS_CYC - 1) : CW'(RP_CYC - 1);
      end
      WV_PRECHG: if (cnt_q == '0) ph_d = WV_IDLE;
      else cnt_d = cnt_q - 1'b1;
      default: ph_d = WV_IDLE;
    endcase
  end

  // strobes registered from next phase: glitch-free pins aligned with phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= WV_IDLE;
      cnt_q   <= '0;
      slf_q   <= 1'b0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      slf_q   <= slf_d;
      ras_n_q <= (ph_d != WV_ACTIVE);
      cas_n_q <= !((ph_d == WV_SETUP) || (ph_d == WV_ACTIVE));
    end
  end

  assign busy_o  = (ph_q != WV_IDLE);
  assign done_o  = (ph_q == WV_PRECHG) && (cnt_q == '0);
  assign ras_n_o = ras_n_q;
  assign cas_n_o = cas_n_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int unsigned CLK_NS          = 10,
  parameter int unsigned PAUSE_NS        = 200000,
  parameter int unsigned INTERVAL_NS     = 15600,
  parameter int unsigned INIT_REFRESHES  = 8,
  parameter int unsigned MAX_PEND        = 8,
  parameter bit          SELF_REFRESH_EN = 1'b1,
  parameter int unsigned T_CSR_NS        = 10,
  parameter int unsigned T_CHR_NS        = 10,
  parameter int unsigned T_RAS_NS        = 60,
  parameter int unsigned T_RP_NS         = 40,
  parameter int unsigned T_RPC_NS        = 5,
  parameter int unsigned T_RASS_NS       = 100000,
  parameter int unsigned T_RPS_NS        = 110
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sr_req_i,
  input  logic gnt_i,
  output logic req_o,
  output logic init_done_o,
  output logic drive_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  localparam int unsigned PAUSE_CYC    = ns2cyc(PAUSE_NS, CLK_NS);
  localparam int unsigned INTERVAL_CYC = (INTERVAL_NS / CLK_NS > 0) ? INTERVAL_NS / CLK_NS : 1;
  localparam int unsigned CSR_CYC      = ns2cyc(T_CSR_NS, CLK_NS);
  localparam int unsigned RAS_CYC      = umax(ns2cyc(T_RAS_NS, CLK_NS), ns2cyc(T_CHR_NS, CLK_NS));
  localparam int unsigned RP_CYC       = umax(ns2cyc(T_RP_NS, CLK_NS), ns2cyc(T_RPC_NS, CLK_NS));
  localparam int unsigned RASS_CYC     = umax(ns2cyc(T_RASS_NS, CLK_NS), RAS_CYC);
  localparam int unsigned RPS_CYC      = umax(ns2cyc(T_RPS_NS, CLK_NS), RP_CYC);
  localparam int unsigned PCW          = $clog2(PAUSE_CYC + 1);
  localparam int unsigned IW           = $clog2(INIT_REFRESHES + 1);

  seq_ph_e        seq_q;
  logic [PCW-1:0] pause_q;
  logic [IW-1:0]  init_q;
  logic           init_done_q;
  logic           sr_go, pend, need, start, busy, wave_done, self_sel;

  generate
    if (SELF_REFRESH_EN) begin : g_sr
      assign sr_go = sr_req_i;
    end else begin : g_no_sr
      assign sr_go = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (seq_q)
      SQ_PAUSE: need = 1'b0;
      SQ_RUN:   need = pend || sr_go;
      default:  need = 1'b1;
    endcase
  end

  // retention request pre-empts a pending refresh only between cycles
  assign start    = need && gnt_i && !busy && !((seq_q == SQ_RUN) && sr_go);
  assign self_sel = (seq_q == SQ_SR_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q       <= SQ_PAUSE;
      pause_q     <= '0;
      init_q      <= '0;
      init_done_q <= 1'b0;
    end else begin
      unique case (seq_q)
        SQ_PAUSE:
          if (pause_q == PCW'(PAUSE_CYC - 1)) seq_q <= SQ_INIT;
          else pause_q <= pause_q + 1'b1;
        SQ_INIT:
          if (wave_done) begin
            if (init_q == IW'(INIT_REFRESHES - 1)) begin
              seq_q       <= SQ_RUN;
              init_done_q <= 1'b1;
            end else init_q <= init_q + 1'b1;
          end
        SQ_RUN:     if (sr_go && !busy) seq_q <= SQ_SR_PRE;
        SQ_SR_PRE:  if (wave_done) seq_q <= SQ_SR_HOLD;
        SQ_SR_HOLD: if (wave_done) seq_q <= SQ_SR_POST;
        SQ_SR_POST: if (wave_done) seq_q <= SQ_RUN;
        default:    seq_q <= SQ_PAUSE;
      endcase
    end
  end

  refresh_pacer #(
    .INTERVAL_CYC(INTERVAL_CYC),
    .MAX_PEND    (MAX_PEND)
  ) u_pacer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (init_done_q),
    .done_i(wave_done && !self_sel),
    .pend_o(pend)
  );

  cbr_wave #(
    .CSR_CYC (CSR_CYC),
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC),
    .RASS_CYC(RASS_CYC),
    .RPS_CYC (RPS_CYC)
  ) u_wave (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .self_i (self_sel),
    .hold_i (sr_req_i),
    .busy_o (busy),
    .done_o (wave_done),
    .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o)
  );

  assign req_o       = need || busy;
  assign drive_o     = busy;
  assign init_done_o = init_done_q;
  assign we_n_o      = 1'b1;
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int unsigned PAUSE_CYC = 100,
  parameter int unsigned RAS_CYC   = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic gnt_i,
  input logic req_o,
  input logic init_done_o,
  input logic drive_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic we_n_o
);
  int unsigned cyc_q, low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= 0;
      low_q <= 0;
    end else begin
      if (cyc_q < PAUSE_CYC) cyc_q <= cyc_q + 1;
      if (!ras_n_o) low_q <= (low_q == 32'hffff_ffff) ? low_q : low_q + 1;
      else          low_q <= 0;
    end
  end

  p_pause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> cyc_q >= PAUSE_CYC);
  p_init_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  p_cas_lead_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $past(!cas_n_o));
  p_cas_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> !cas_n_o);
  p_we_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> we_n_o);
  p_ras_min_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> low_q >= RAS_CYC);
  p_drive_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> req_o);
  p_strobe_gnt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) |-> gnt_i && drive_o);
  p_req_wait_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i && !drive_o) |=> req_o);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .PAUSE_CYC(PAUSE_CYC),
  .RAS_CYC  (RAS_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gnt_i      (gnt_i),
  .req_o      (req_o),
  .init_done_o(init_done_o),
  .drive_o    (drive_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .we_n_o     (we_n_o)
);

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;
  localparam int CLK_NS       = 20;
  localparam int PAUSE_NS     = 2000;
  localparam int INTERVAL_NS  = 2000;
  localparam int RASS_NS      = 400;
  localparam int PAUSE_CYC    = (PAUSE_NS + CLK_NS - 1) / CLK_NS;
  localparam int INTERVAL_CYC = INTERVAL_NS / CLK_NS;
  localparam int CSR_CYC      = (10 + CLK_NS - 1) / CLK_NS;
  localparam int RAS_CYC      = (60 + CLK_NS - 1) / CLK_NS;
  localparam int RP_CYC       = (40 + CLK_NS - 1) / CLK_NS;
  localparam int RASS_CYC     = (RASS_NS + CLK_NS - 1) / CLK_NS;
  localparam int RPS_CYC      = (110 + CLK_NS - 1) / CLK_NS;
  localparam int GNT_MAX      = 5;
  localparam int SPACE_MAX    = INTERVAL_CYC + RAS_CYC + RP_CYC + CSR_CYC + GNT_MAX + 5;

  logic clk = 1'b0, rst_ni = 1'b0, sr_req = 1'b0, gnt = 1'b0;
  logic req, init_done, drive, ras_n, cas_n, we_n;

  always #10 clk = ~clk;

  dram_refresh_seq #(
    .CLK_NS(CLK_NS), .PAUSE_NS(PAUSE_NS), .INTERVAL_NS(INTERVAL_NS), .T_RASS_NS(RASS_NS)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sr_req_i(sr_req), .gnt_i(gnt), .req_o(req),
    .init_done_o(init_done), .drive_o(drive), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n)
  );

  int checks = 0, fails = 0;
  bit fin = 1'b0, hold_gnt = 1'b0, space_en = 1'b0;

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // grant driver: random latency, released when request drops
  initial begin
    forever begin
      @(negedge clk);
      if (hold_gnt || !req) gnt = 1'b0;
      else if (!gnt) begin
        int lat = int'($urandom_range(0, GNT_MAX));
        repeat (lat) @(negedge clk);
        if (req && !hold_gnt) gnt = 1'b1;
      end
    end
  end

  // strobe monitor
  int cyc = 0, ras_low = 0, cas_lead = 0, since_rise = 1000, last_low = 0;
  int t_fall_last = 0, t_fall_prev = 0, falls = 0;
  int sr_low = 0, sr_pre_gap = 0, sr_post_gap = 0, sr_rise_t = 0;
  bit ras_p = 1'b1, cas_p = 1'b1, cas_ok = 1'b1, space_have = 1'b0;
  bit sr_wait_post = 1'b0, sr_post_seen = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (ras_p && !ras_n) begin
        chk(cas_lead >= CSR_CYC, "R4 cas lead", cas_lead, CSR_CYC);
        chk(we_n == 1'b1, "R5 we high", int'(we_n), 1);
        chk(drive && gnt, "R8 drive+gnt", int'({drive, gnt}), 3);
        if (space_en) begin
          if (space_have) chk(cyc - t_fall_last <= SPACE_MAX, "R7 spacing", cyc - t_fall_last, SPACE_MAX);
          space_have = 1'b1;
        end else space_have = 1'b0;
        if (sr_wait_post) begin
          sr_post_gap  = cyc - sr_rise_t;
          sr_wait_post = 1'b0;
          sr_post_seen = 1'b1;
        end
        t_fall_prev = t_fall_last;
        t_fall_last = cyc;
        falls++;
        cas_ok = 1'b1;
      end
      if (!ras_p && ras_n) begin
        chk(ras_low >= RAS_CYC, "R6 ras low", ras_low, RAS_CYC);
        chk(cas_ok, "R4 cas held", int'(cas_ok), 1);
        if (ras_low > RAS_CYC + 2) begin
          sr_low       = ras_low;
          sr_pre_gap   = t_fall_last - t_fall_prev;
          sr_rise_t    = cyc;
          sr_wait_post = 1'b1;
        end
        last_low   = ras_low;
        since_rise = 0;
      end
      if (cas_p && !cas_n) begin
        if (last_low > RAS_CYC + 2) chk(since_rise >= RPS_CYC, "R11 exit precharge", since_rise, RPS_CYC);
        else                        chk(since_rise >= RP_CYC, "R6 precharge", since_rise, RP_CYC);
      end
      if (!ras_n && cas_n) cas_ok = 1'b0;
    end
    ras_low  = ras_n ? 0 : ras_low + 1;
    cas_lead = (!cas_n && ras_n) ? cas_lead + 1 : 0;
    if (ras_n) since_rise++;
    ras_p = ras_n;
    cas_p = cas_n;
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!fin) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int f0, extra;
    bit dropped;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk(!req, "R1 req", int'(req), 0);
    chk(!init_done, "R1 init_done", int'(init_done), 0);
    chk(!drive, "R1 drive", int'(drive), 0);
    chk(ras_n && cas_n, "R1 strobes", int'({ras_n, cas_n}), 3);
    rst_ni = 1'b1;
    repeat (PAUSE_CYC - 1) @(negedge clk);
    chk(!req, "R2 before pause end", int'(req), 0);
    @(negedge clk);
    chk(req, "R2 after pause end", int'(req), 1);

    while (!init_done) @(negedge clk);
    chk(falls == 8, "R3 init refresh count", falls, 8);

    // distributed refresh with random grant latency
    space_en = 1'b1;
    f0 = falls;
    repeat (8 * INTERVAL_CYC) @(negedge clk);
    chk(falls - f0 >= 7, "R7 refresh count", falls - f0, 7);
    chk(init_done, "R3 init sticky", int'(init_done), 1);
    space_en = 1'b0;

    // postponed refreshes
    while (req) @(negedge clk);
    hold_gnt = 1'b1;
    while (!req) @(negedge clk);
    f0 = falls;
    dropped = 1'b0;
    repeat (2 * INTERVAL_CYC + INTERVAL_CYC / 2) begin
      @(negedge clk);
      if (!req) dropped = 1'b1;
    end
    chk(!dropped, "R9 req held", int'(dropped), 0);
    chk(falls == f0, "R8 no strobe without gnt", falls - f0, 0);
    chk(!drive, "R8 no drive without gnt", int'(drive), 0);
    hold_gnt = 1'b0;
    @(negedge clk);
    while (req) @(negedge clk);
    chk(falls - f0 == 3, "R10 back-to-back", falls - f0, 3);
    chk(!drive && ras_n && cas_n, "R9 release", int'({drive, ras_n, cas_n}), 3);

    // retention entry and exit
    while (req) @(negedge clk);
    sr_req = 1'b1;
    while (!(!ras_n && ras_low > RAS_CYC + 2)) @(negedge clk);
    extra = int'($urandom_range(0, 30));
    repeat (extra) @(negedge clk);
    sr_req = 1'b0;
    while (!sr_post_seen) @(negedge clk);
    chk(sr_low >= RASS_CYC, "R11 hold min", sr_low, RASS_CYC);
    chk(sr_low >= RAS_CYC + 3 + extra, "R11 hold follows request", sr_low, RAS_CYC + 3 + extra);
    chk(sr_pre_gap <= RAS_CYC + RP_CYC + CSR_CYC + 3, "R11 refresh before",
        sr_pre_gap, RAS_CYC + RP_CYC + CSR_CYC + 3);
    chk(sr_post_gap <= RPS_CYC + CSR_CYC + 4, "R11 refresh after", sr_post_gap, RPS_CYC + CSR_CYC + 4);

    // steady refresh again after exit
    while (req) @(negedge clk);
    space_en = 1'b1;
    f0 = falls;
    repeat (3 * INTERVAL_CYC) @(negedge clk);
    chk(falls - f0 >= 2, "R7 refresh after exit", falls - f0, 2);
    space_en = 1'b0;

    fin = 1'b1;
    summary();
    $finish;
  end
endmodule